// File: doc/BRIEF.md
# Descriptor Auto-Poll Timer

This block paces a DMA engine's descriptor-ring rechecks. It has one timer for the transmit ring and one for the receive ring. Each timer raises a one-clock poll request at a fixed interval, so the engine rechecks its ring without any software write. The interval is a 4-bit count of "units". The length of a unit depends on a short/long selector for that direction and on the link speed. A count of zero turns off periodic polling for that direction.

Software can also demand a poll directly. A demand strobe produces a poll pulse on the next cycle and restarts that direction's interval. When the timing fields of the control word change, or the speed input changes, both intervals restart from zero. Bits of the control word outside the timing fields are ignored.

Top module: `desc_poll_timer`

## Requirements
- R1: The transmit timer takes its count n from cfg[11:8] and its unit selector from cfg[12]. When n is not 0, tx_poll pulses every n units.
- R2: The receive timer takes its count n from cfg[3:0] and its unit selector from cfg[4]. When n is not 0, rx_poll pulses every n units.
- R3: A short unit (selector 0) lasts SHORT_UNIT_CLKS clocks when fast=1, which is the 100 Mbps setting. A long unit (selector 1) is LONG_SCALE times a short unit. With fast=0 (10 Mbps), every unit is SLOW_SCALE times longer. With the defaults 4/16/10 this gives 4, 64, 40 and 640 clocks.
- R4: A count of 0 stops all periodic pulses for that direction.
- R5: Each poll request is high for exactly one clock, unless a demand strobe arrives in the cycle right after it.
- R6: A demand strobe sampled at a clock edge drives that direction's poll output high right after that edge. The next periodic pulse then follows one full interval later.
- R7: A demand strobe produces a pulse even when that direction's count is 0.
- R8: If the timing fields or the fast input differ from their registered values at a clock edge, both timers restart at that edge. With the new setting, the next periodic pulse arrives one full interval after that edge.
- R9: While rst_n is low, both poll outputs are low and both timers are held at zero.
- R10: The registered setting resets to PACE_CFG_DEFAULT = 13'h0001 with fast=1. This turns transmit polling off and sets receive polling to one short unit. Without any input change, rx_poll therefore first pulses at the 4th edge after reset is released.
- R11: Bits cfg[7:5] are ignored. Changing only those bits neither restarts a timer nor moves a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 13 | Poll timing control word |
| fast | input | 1 | Speed select: 1 = 100 Mbps, 0 = 10 Mbps |
| sw_tx_kick | input | 1 | Software poll demand, transmit |
| sw_rx_kick | input | 1 | Software poll demand, receive |
| tx_poll | output | 1 | Transmit poll request pulse |
| rx_poll | output | 1 | Receive poll request pulse |

## Verification
The bench measures the edge index of the first and second pulse in each direction. This exposes three kinds of timing error: an interval that is off by one clock, a unit scaled by the wrong factor, and a zero count that still fires. It restarts a running interval in two ways, by changing the count and by flipping only the speed. A design that ignores either change keeps the old phase and fires at the wrong edge. It toggles only the unused bits mid-interval; a design that compares the whole word would restart and fire six edges late. It issues demand strobes with one direction disabled. A design that gates demands with the count, or does not reload the counter after a demand, fails on that direction's pulse times.

// File: rtl/poll_pkg.sv
`timescale 1ns/1ps
package poll_pkg;

  localparam int CFG_W  = 13;
  localparam int CNT_N_W = 4;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  localparam logic [CFG_W-1:0] PACE_CFG_DEFAULT = 13'h0001;

  typedef struct packed {
    logic                 long_unit;
    logic [CNT_N_W-1:0]   n;
  } lane_cfg_t;

  function automatic lane_cfg_t lane_fields(logic [CFG_W-1:0] word, int dir);
    lane_cfg_t f;
    if (dir == DIR_TX) begin
      f.long_unit = word[12];
      f.n         = word[11:8];
    end else begin
      f.long_unit = word[4];
      f.n         = word[3:0];
    end
    return f;
  endfunction

  function automatic int unsigned unit_clks(logic long_unit, logic fast,
                                            int unsigned short_clks,
                                            int unsigned long_scale,
                                            int unsigned slow_scale);
    int unsigned u;
    u = short_clks;
    if (long_unit) u = u * long_scale;
    if (!fast)     u = u * slow_scale;
    return u;
  endfunction

  function automatic int unsigned pace_period(lane_cfg_t f, logic fast,
                                              int unsigned short_clks,
                                              int unsigned long_scale,
                                              int unsigned slow_scale);
    return unit_clks(f.long_unit, fast, short_clks, long_scale, slow_scale)
           * 32'(f.n);
  endfunction

endpackage

// File: rtl/pace_cfg_reg.sv
`timescale 1ns/1ps
module pace_cfg_reg
  import poll_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CFG_W-1:0]      cfg,
  input  logic                  fast,
  output lane_cfg_t [1:0]       lane_q,
  output logic                  fast_q,
  output logic                  restart
);

  lane_cfg_t [1:0] lane_now;
  logic            unused_cfg_bits;

  assign unused_cfg_bits = ^cfg[7:5];

  always_comb begin
    lane_now[DIR_TX] = lane_fields(cfg, DIR_TX);
    lane_now[DIR_RX] = lane_fields(cfg, DIR_RX);
  end

  assign restart = (lane_now != lane_q) || (fast != fast_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q[DIR_TX] <= lane_fields(PACE_CFG_DEFAULT, DIR_TX);
      lane_q[DIR_RX] <= lane_fields(PACE_CFG_DEFAULT, DIR_RX);
      fast_q         <= 1'b1;
    end else begin
      lane_q <= lane_now;
      fast_q <= fast;
    end
  end

endmodule

// File: rtl/pace_lane.sv
`timescale 1ns/1ps
module pace_lane
  import poll_pkg::*;
#(
  parameter int CNT_W           = 14,
  parameter int SHORT_UNIT_CLKS = 4,
  parameter int LONG_SCALE      = 16,
  parameter int SLOW_SCALE      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_cfg_t        lcfg,
  input  logic             fast,
  input  logic             restart,
  input  logic             kick,
  output logic             poll,
  output logic             off,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period
);

  logic wrap;

  assign period = CNT_W'(pace_period(lcfg, fast, SHORT_UNIT_CLKS,
                                     LONG_SCALE, SLOW_SCALE));
  assign off    = (lcfg.n == '0);
  assign wrap   = !off && (cnt == period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      poll <= 1'b0;
    end else if (kick) begin
      cnt  <= '0;
      poll <= 1'b1;
    end else if (restart) begin
      cnt  <= '0;
      poll <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      poll <= 1'b1;
    end else begin
      cnt  <= off ? '0 : cnt + CNT_W'(1);
      poll <= 1'b0;
    end
  end

endmodule

// File: rtl/desc_poll_timer.sv
`timescale 1ns/1ps
module desc_poll_timer
  import poll_pkg::*;
#(
  parameter int SHORT_UNIT_CLKS = 4,
  parameter int LONG_SCALE      = 16,
  parameter int SLOW_SCALE      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [12:0]      cfg,
  input  logic             fast,
  input  logic             sw_tx_kick,
  input  logic             sw_rx_kick,
  output logic             tx_poll,
  output logic             rx_poll
);

  localparam int MAX_N      = (1 << CNT_N_W) - 1;
  localparam int MAX_PERIOD = MAX_N * SHORT_UNIT_CLKS * LONG_SCALE * SLOW_SCALE;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  lane_cfg_t [1:0]            lane_q;
  logic                       fast_q;
  logic                       restart;
  logic [1:0]                 kick;
  logic [1:0]                 poll;
  logic [1:0]                 lane_off;
  logic [1:0][CNT_W-1:0]      lane_cnt;
  logic [1:0][CNT_W-1:0]      lane_period;

  assign kick[DIR_TX] = sw_tx_kick;
  assign kick[DIR_RX] = sw_rx_kick;
  assign tx_poll      = poll[DIR_TX];
  assign rx_poll      = poll[DIR_RX];

  pace_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .fast    (fast),
    .lane_q  (lane_q),
    .fast_q  (fast_q),
    .restart (restart)
  );

  for (genvar d = 0; d < 2; d++) begin : g_lane
    pace_lane #(
      .CNT_W           (CNT_W),
      .SHORT_UNIT_CLKS (SHORT_UNIT_CLKS),
      .LONG_SCALE      (LONG_SCALE),
      .SLOW_SCALE      (SLOW_SCALE)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .lcfg    (lane_q[d]),
      .fast    (fast_q),
      .restart (restart),
      .kick    (kick[d]),
      .poll    (poll[d]),
      .off     (lane_off[d]),
      .cnt     (lane_cnt[d]),
      .period  (lane_period[d])
    );
  end

endmodule

// File: rtl/desc_poll_timer_chk.sv
`timescale 1ns/1ps
module desc_poll_timer_chk #(
  parameter int CNT_W = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  restart,
  input logic [1:0]            kick,
  input logic [1:0]            poll,
  input logic [1:0]            lane_off,
  input logic [1:0][CNT_W-1:0] lane_cnt,
  input logic [1:0][CNT_W-1:0] lane_period
);

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (poll == 2'b00 && lane_cnt[0] == '0 && lane_cnt[1] == '0);
    end
  end

  p_cnt_range_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lane_off[0] ? (lane_cnt[0] == '0) : (lane_cnt[0] < lane_period[0]));
  p_cnt_range_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_off[1] ? (lane_cnt[1] == '0) : (lane_cnt[1] < lane_period[1]));

  p_off_silent_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_off[0] && !kick[0]) |=> !poll[0]);
  p_off_silent_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_off[1] && !kick[1]) |=> !poll[1]);

  p_single_pulse_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll[0] && !kick[0]) |=> !poll[0]);
  p_single_pulse_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll[1] && !kick[1]) |=> !poll[1]);

  p_kick_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick[0] |=> (poll[0] && lane_cnt[0] == '0));
  p_kick_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick[1] |=> (poll[1] && lane_cnt[1] == '0));

  p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (lane_cnt[0] == '0 && lane_cnt[1] == '0));
  p_restart_quiet_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !kick[0]) |=> !poll[0]);
  p_restart_quiet_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !kick[1]) |=> !poll[1]);

endmodule

bind desc_poll_timer desc_poll_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .kick        (kick),
  .poll        (poll),
  .lane_off    (lane_off),
  .lane_cnt    (lane_cnt),
  .lane_period (lane_period)
);

// File: tb/test_desc_poll_timer.sv
`timescale 1ns/1ps
module test_desc_poll_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cfg = 13'h0001;
  logic        fast = 1'b1;
  logic        sw_tx_kick = 1'b0;
  logic        sw_rx_kick = 1'b0;
  logic        tx_poll, rx_poll;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  desc_poll_timer i_desc_poll_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .fast       (fast),
    .sw_tx_kick (sw_tx_kick),
    .sw_rx_kick (sw_rx_kick),
    .tx_poll    (tx_poll),
    .rx_poll    (rx_poll)
  );

  // {cfg, fast}; each entry changes the timing fields of the one before
  localparam logic [13:0] VEC [8] = '{
    {13'h0203, 1'b1}, {13'h1100, 1'b1}, {13'h0015, 1'b1}, {13'h0F01, 1'b0},
    {13'h1202, 1'b0}, {13'h0000, 1'b1}, {13'h1F1F, 1'b1}, {13'h03E1, 1'b1}
  };

  // clocks per interval, from R3: 4 clocks per short fast unit
  function automatic int interval(logic [3:0] n, logic lng, logic fst);
    int per_unit;
    case ({lng, fst})
      2'b01:   per_unit = 4;
      2'b11:   per_unit = 64;
      2'b00:   per_unit = 40;
      default: per_unit = 640;
    endcase
    return per_unit * int'(n);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edge i=1 is the first edge after the call; records first two pulses
  task automatic measure(input int win, output int ft, output int st,
                         output int fr, output int sr, output int wide);
    int pt, pr;
    pt = 0; pr = 0; ft = -1; st = -1; fr = -1; sr = -1; wide = 0;
    for (int i = 1; i <= win; i++) begin
      @(posedge clk);
      #2;
      sw_tx_kick = 1'b0;
      sw_rx_kick = 1'b0;
      @(negedge clk);
      if (tx_poll) begin
        if (ft < 0) ft = i; else if (st < 0) st = i;
        if (pt != 0) wide = 1;
      end
      if (rx_poll) begin
        if (fr < 0) fr = i; else if (sr < 0) sr = i;
        if (pr != 0) wide = 1;
      end
      pt = int'(tx_poll);
      pr = int'(rx_poll);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ft, st, fr, sr, wide, ptx, prx, win;
    logic [12:0] c;
    logic f;

    // R9: quiet in reset
    repeat (3) @(negedge clk);
    chk("R9", "tx_poll in reset", int'(tx_poll), 0);
    chk("R9", "rx_poll in reset", int'(rx_poll), 0);

    // R10: default setting after release
    rst_n = 1'b1;
    measure(20, ft, st, fr, sr, wide);
    chk("R10", "default rx first pulse", fr, 4);
    chk("R10", "default rx second pulse", sr, 8);
    chk("R10", "default tx silent", ft, -1);

    // R1 R2 R3 R4 R5: table walk; edge 1 is the restart edge
    for (int v = 0; v < 8; v++) begin
      c = VEC[v][13:1];
      f = VEC[v][0];
      ptx = interval(c[11:8], c[12], f);
      prx = interval(c[3:0], c[4], f);
      win = ((ptx > prx) ? ptx : prx) * 2 + 4;
      cfg = c;
      fast = f;
      measure(win, ft, st, fr, sr, wide);
      chk("R1", $sformatf("vec%0d tx first", v), ft, (ptx == 0) ? -1 : 1 + ptx);
      chk("R1", $sformatf("vec%0d tx second", v), st, (ptx == 0) ? -1 : 1 + 2 * ptx);
      chk("R2", $sformatf("vec%0d rx first", v), fr, (prx == 0) ? -1 : 1 + prx);
      chk("R2", $sformatf("vec%0d rx second", v), sr, (prx == 0) ? -1 : 1 + 2 * prx);
      chk("R5", $sformatf("vec%0d pulse width", v), wide, 0);
    end

    // R8: count change mid-interval restarts
    cfg = 13'h0400; fast = 1'b1;
    measure(10, ft, st, fr, sr, wide);
    chk("R8", "no pulse before change", ft, -1);
    cfg = 13'h0200;
    measure(20, ft, st, fr, sr, wide);
    chk("R8", "tx first after count change", ft, 9);
    chk("R8", "tx second after count change", st, 17);

    // R8: speed-only change restarts
    fast = 1'b0;
    measure(170, ft, st, fr, sr, wide);
    chk("R8", "tx first after speed change", ft, 81);
    chk("R8", "tx second after speed change", st, 161);

    // R6 R7: demand strobes, rx count 0
    cfg = 13'h0400; fast = 1'b1;
    measure(5, ft, st, fr, sr, wide);
    sw_tx_kick = 1'b1;
    sw_rx_kick = 1'b1;
    measure(40, ft, st, fr, sr, wide);
    chk("R6", "tx pulse on demand", ft, 1);
    chk("R6", "tx interval reloaded", st, 17);
    chk("R7", "rx pulse on demand while off", fr, 1);
    chk("R4", "rx no periodic pulse", sr, -1);

    // R11: unused bits ignored
    cfg = 13'h0500;
    measure(6, ft, st, fr, sr, wide);
    chk("R11", "no pulse before junk write", ft, -1);
    cfg = 13'h05E0;
    measure(40, ft, st, fr, sr, wide);
    chk("R11", "tx first unmoved", ft, 15);
    chk("R11", "tx second unmoved", st, 35);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule